// File: doc/BRIEF.md
# Masked Multi-Address Slave Matcher

This block is the slave-side address recognizer of a two-wire serial bus controller. When the shift logic has assembled the first byte after a start condition, it presents that byte with a one-cycle valid strobe. The matcher compares the upper seven bits with four programmable own addresses in parallel. Each address has its own mask, and a mask bit of one removes the matching address bit from the comparison. The lowest bit of the byte is the transfer direction and is passed through.

Each address register also carries an enable bit for the general call. When any slot has that bit set, the all-zero byte is accepted as a general call. While the controller acts as a bus master, the matcher stays silent. One cycle after the strobe, the block reports the result: a match pulse, the index of the winning slot, a general-call flag and the direction bit. Acknowledge generation, bit shifting and status codes belong to neighbouring blocks.

Top module: `multi_addr_matcher`

## Requirements
- R1: Slot k matches when bits 7:1 of `rx_byte` equal bits 7:1 of byte k of `own_addr` (byte k is bits 8k+7:8k), in every bit position that the mask does not exclude.
- R2: A 1 in bit j of mask field k (bits 7k+6:7k of `addr_mask`, bit j compares against address bit j+1) makes that address bit don't-care for slot k. A 0 requires equality.
- R3: When several slots match, `match_idx` reports the lowest-numbered matching slot.
- R4: The byte 0x00 is accepted as a general call when bit 0 of any `own_addr` byte is set. The result is `gc_hit`=1, and `match_idx` gives the lowest slot whose bit 0 is set.
- R5: A byte whose bits 7:1 are all zero never matches through the address comparison. 0x00 with no general-call enable, and 0x01 in every case, give no pulse.
- R6: While `is_master` is 1, no strobe produces a match pulse.
- R7: `match_pulse` is high exactly in the cycle after an accepted strobe, for one cycle per strobe. `match_idx`, `gc_hit` and `rw_bit` take their new values in that same cycle.
- R8: `match_idx`, `gc_hit` and `rw_bit` keep their values in every cycle without a match pulse, including after rejected strobes.
- R9: `rw_bit` equals bit 0 of the accepted byte.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received address byte |
| rx_byte | input | 8 | Address byte, direction in bit 0 |
| is_master | input | 1 | Controller is in master mode |
| own_addr | input | 32 | Four address bytes: bits 7:1 address, bit 0 general-call enable |
| addr_mask | input | 28 | Four 7-bit don't-care masks |
| match_pulse | output | 1 | Registered one-cycle match indication |
| match_idx | output | 2 | Index of the winning slot |
| gc_hit | output | 1 | Accepted byte was a general call |
| rw_bit | output | 1 | Direction bit of the accepted byte |

## Verification
The assertions check on every cycle the properties of timing and of being silent: a pulse only follows a strobe, master mode gives no pulse, the result fields hold between pulses, a general call always has direction 0, and the reported slot is one that actually matched. The assertions cannot state what the correct comparison result is. Correct masking, lowest-slot priority and general-call slot choice appear only in the bench scenarios. These scenarios use directed overlaps of slots and random addresses whose masks make collisions likely.

// File: rtl/amatch_pkg.sv
package amatch_pkg;
  localparam int unsigned DEF_SLOTS  = 4;
  localparam int unsigned DEF_ADDR_W = 7;
  localparam int unsigned BYTE_W     = DEF_ADDR_W + 1;

  typedef enum logic {DIR_WRITE = 1'b0, DIR_READ = 1'b1} dir_e;
endpackage

// File: rtl/slot_compare.sv
module slot_compare #(
  parameter int unsigned ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [ADDR_W-1:0] own,
  input  logic [ADDR_W-1:0] care_off,
  output logic              hit
);
  logic [ADDR_W-1:0] diff;
  logic              reserved;

  always_comb begin
    diff     = (rx_addr ^ own) & ~care_off;
    reserved = (rx_addr == '0);
    hit      = (diff == '0) && !reserved;
  end
endmodule

// File: rtl/lowest_first.sv
module lowest_first #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/multi_addr_matcher.sv
module multi_addr_matcher
  import amatch_pkg::*;
#(
  parameter int unsigned SLOTS  = DEF_SLOTS,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  localparam int unsigned RB_W  = ADDR_W + 1,
  localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    byte_valid,
  input  logic [RB_W-1:0]         rx_byte,
  input  logic                    is_master,
  input  logic [SLOTS*RB_W-1:0]   own_addr,
  input  logic [SLOTS*ADDR_W-1:0] addr_mask,
  output logic                    match_pulse,
  output logic [IDX_W-1:0]        match_idx,
  output logic                    gc_hit,
  output logic                    rw_bit
);
  logic [ADDR_W-1:0] rx_addr;
  logic [SLOTS-1:0]  slot_hit;
  logic [SLOTS-1:0]  gc_en;
  logic              any_slot, any_gc;
  logic [IDX_W-1:0]  slot_idx, gc_idx;

  assign rx_addr = rx_byte[RB_W-1:1];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign gc_en[k] = own_addr[k*RB_W];
    slot_compare #(.ADDR_W(ADDR_W)) u_cmp (
      .rx_addr (rx_addr),
      .own     (own_addr[k*RB_W+1 +: ADDR_W]),
      .care_off(addr_mask[k*ADDR_W +: ADDR_W]),
      .hit     (slot_hit[k])
    );
  end

  lowest_first #(.N(SLOTS), .IDX_W(IDX_W)) u_slot_pick (
    .req(slot_hit), .any(any_slot), .idx(slot_idx)
  );
  lowest_first #(.N(SLOTS), .IDX_W(IDX_W)) u_gc_pick (
    .req(gc_en), .any(any_gc), .idx(gc_idx)
  );

  logic             is_gc_byte, take_gc, accept;
  logic             pulse_d;
  logic [IDX_W-1:0] idx_d;
  logic             gc_d, rw_d;
  logic             load_en;

  always_comb begin
    is_gc_byte = (rx_byte == '0);
    take_gc    = is_gc_byte && any_gc;
    accept     = byte_valid && !is_master && (take_gc || any_slot);
    load_en    = accept;
    pulse_d    = accept;
    idx_d      = take_gc ? gc_idx : slot_idx;
    gc_d       = take_gc;
    rw_d       = rx_byte[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_pulse <= 1'b0;
    end else begin
      match_pulse <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_idx <= '0;
      gc_hit    <= 1'b0;
      rw_bit    <= 1'b0;
    end else if (load_en) begin
      match_idx <= idx_d;
      gc_hit    <= gc_d;
      rw_bit    <= rw_d;
    end
  end

  // R6: master mode never yields a pulse
  a_r6_master_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && is_master) |=> !match_pulse);

  // R7: a pulse is always preceded by a strobe
  a_r7_pulse_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(byte_valid));

  // R8: result fields hold between pulses
  a_r8_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    !match_pulse |-> $stable({match_idx, gc_hit, rw_bit}));

  // R4: a general call always carries the write direction
  a_r4_gc_write: assert property (@(posedge clk) disable iff (!rst_n)
    (match_pulse && gc_hit) |-> (rw_bit == DIR_WRITE));

  // R3: a non-general-call result names a slot that actually hit
  a_r3_idx_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !is_master && any_slot && !take_gc) |-> slot_hit[slot_idx]);

  // R5: the reserved all-zero address field never hits a slot comparator
  a_r5_reserved_no_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_addr == '0) |-> (slot_hit == '0));
endmodule

// File: tb/multi_addr_matcher_test.sv
`timescale 1ns/1ps
module multi_addr_matcher_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_valid;
  logic [7:0]  rx_byte;
  logic        is_master;
  logic [31:0] own_addr;
  logic [27:0] addr_mask;
  logic        match_pulse;
  logic [1:0]  match_idx;
  logic        gc_hit;
  logic        rw_bit;

  int checks = 0;
  int fails  = 0;

  logic [1:0] h_idx;
  logic       h_gc, h_rw;

  always #2.5 clk = ~clk;

  multi_addr_matcher uut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .rx_byte(rx_byte),
    .is_master(is_master), .own_addr(own_addr), .addr_mask(addr_mask),
    .match_pulse(match_pulse), .match_idx(match_idx), .gc_hit(gc_hit),
    .rw_bit(rw_bit)
  );

  function automatic logic [4:0] model(input logic [7:0] b, input logic m,
                                       input logic [31:0] oa, input logic [27:0] am);
    logic       hit = 1'b0;
    logic [1:0] idx = 2'd0;
    logic       gc  = 1'b0;
    if (!m) begin
      if (b == 8'h00) begin
        for (int k = 3; k >= 0; k--)
          if (oa[8*k]) begin hit = 1'b1; gc = 1'b1; idx = 2'(k); end
      end else if (b[7:1] != 7'd0) begin
        for (int k = 3; k >= 0; k--)
          if (((b[7:1] ^ oa[8*k+1 +: 7]) & ~am[7*k +: 7]) == 7'd0) begin
            hit = 1'b1; idx = 2'(k);
          end
      end
    end
    return {hit, idx, gc, b[0]};
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got pulse/idx/gc/rw=%b expected %b", req, act, exp);
    end
  endtask

  task automatic send(input string req, input logic [7:0] b, input logic m);
    logic [4:0] e;
    e = model(b, m, own_addr, addr_mask);
    @(negedge clk);
    rx_byte = b; is_master = m; byte_valid = 1'b1;
    @(negedge clk);
    byte_valid = 1'b0;
    if (e[4]) begin h_idx = e[3:2]; h_gc = e[1]; h_rw = e[0]; end
    check(req, {match_pulse, match_idx, gc_hit, rw_bit}, {e[4], h_idx, h_gc, h_rw});
    @(negedge clk);
    check("R7/R8 after pulse", {match_pulse, match_idx, gc_hit, rw_bit},
          {1'b0, h_idx, h_gc, h_rw});
  endtask

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd7;
    void'($urandom(seed));
    rst_n = 1'b0; byte_valid = 1'b0; rx_byte = 8'h00; is_master = 1'b0;
    own_addr = 32'h0; addr_mask = 28'h0;
    h_idx = 2'd0; h_gc = 1'b0; h_rw = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset", {match_pulse, match_idx, gc_hit, rw_bit}, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // slots: 0x50, 0x21, 0x50 (masked), 0x3C
    own_addr  = {8'h78, 8'hA0, 8'h42, 8'hA0};
    addr_mask = {7'h00, 7'h0F, 7'h00, 7'h00};
    send("R1 exact slot1 write", 8'h42, 1'b0);
    send("R9 exact slot3 read", 8'h79, 1'b0);
    send("R3 slots 0 and 2 both hit -> 0", 8'hA1, 1'b0);
    send("R2 masked low bits slot2", 8'hAE, 1'b0);
    send("R2 masked bit mismatch outside mask", 8'hCE, 1'b0);
    send("R6 master mode silent", 8'h42, 1'b1);
    send("R5 zero without gc enable", 8'h00, 1'b0);
    own_addr[16] = 1'b1; own_addr[24] = 1'b1;
    send("R4 general call lowest enabled slot 2", 8'h00, 1'b0);
    send("R5 0x01 never matches", 8'h01, 1'b0);
    send("R8 miss keeps fields", 8'h10, 1'b0);
    addr_mask = {7'h7F, 7'h00, 7'h00, 7'h00};
    send("R2 full mask slot3", 8'h33, 1'b0);
    send("R6 master general call silent", 8'h00, 1'b1);

    for (int n = 0; n < 300; n++) begin
      own_addr  = $urandom;
      addr_mask = 28'($urandom & $urandom);
      send("R1/R2/R3/R4 random", (n % 17 == 0) ? 8'h00 : 8'($urandom),
           ($urandom % 8) == 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule